// File: doc/BRIEF.md
# Subcode Block Sync and Q-Channel CRC Checker

This block sits after the demodulator of a disc data path. It takes one 8-bit subcode symbol for each frame, along with two flags that mark the two subcode sync patterns. A subcode block begins when a frame flagged as the first sync pattern is followed at once by a frame flagged as the second. When the block sees that pair, it raises a block-sync level.

Only the Q bit of each data frame is used. That bit goes into a CRC engine and into an 80-stage shift register. On each block-sync rising edge, the block latches a verdict for the Q data collected since the previous sync:

- High means the block had the right length and its check field matched.
- Low means an error.

The verdict is held until the next sync. For bring-up, a debug enable can also place the verdict on a serial pin. The verdict stays there until a falling edge of an externally supplied readout clock.

Symbols arrive on a valid/ready stream. The block never applies back-pressure: ready is high whenever reset is released. Every cycle with valid high is one frame. Frames may be separated by any number of idle cycles.

Top module: `qsub_sync_crc`

## Requirements
- R1: `sym_ready` is high whenever `rst_n` is high. A frame is a cycle with `sym_valid` and `sym_ready` both high, and no frame is ever refused.
- R2: A frame with `sym_s1` set, accepted directly after a frame with `sym_s0` set, raises `blk_sync` from the next cycle. `blk_sync` stays high through idle cycles and falls after the next accepted frame.
- R3: If the frame after an S0 frame lacks S1, the pending S0 is dropped and no sync is raised. An S1 frame that has no S0 frame just before it raises no sync.
- R4: The Q bit is `sym_data[6]`, with P in bit 7 and W in bit 0. Frames that carry S0 or S1 are not data frames. `q_shift` holds the Q bits of the last 80 data frames, with the newest in bit 0.
- R5: On each `blk_sync` rise, `q_ok` is set high if both of the following hold, and low otherwise:
  - exactly 96 data frames arrived since the previous sync (or since reset);
  - the CRC of the first 80 Q bits equals the bitwise complement of the last 16 Q bits. The CRC uses x^16+x^12+x^5+1, zero preset, first bit first, and the first check bit received is the CRC MSB.
- R6: `q_ok` changes only on a `blk_sync` rise. `q_ok` is low after reset.
- R7: When `crc_dbg_en` is high at a `blk_sync` rise, `q_ser` carries `q_ok` from the next cycle. It stays that way until the cycle after a falling edge of `rd_clk`. `q_ser` is low whenever `crc_dbg_en` is low.
- R8: After reset, `blk_sync`, `q_ok`, `q_ser` and `q_shift` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A subcode symbol is offered |
| sym_ready | output | 1 | Symbol accepted (high out of reset) |
| sym_data | input | 8 | Subcode symbol, P in bit 7 through W in bit 0 |
| sym_s0 | input | 1 | Symbol is the first sync pattern |
| sym_s1 | input | 1 | Symbol is the second sync pattern |
| crc_dbg_en | input | 1 | Enables the serial verdict output |
| rd_clk | input | 1 | Serial readout clock, sampled on clk |
| blk_sync | output | 1 | Subcode block sync level |
| q_ok | output | 1 | Latched CRC verdict, high means good |
| q_ser | output | 1 | Serial copy of the verdict in debug mode |
| q_shift | output | 80 | Last 80 data-frame Q bits, newest in bit 0 |

## Verification
The assertions assume two things about the inputs:
- `rd_clk` changes slowly enough relative to `clk` that each of its levels is sampled at least once.
- The sync flags appear only on valid cycles.

The stimulus keeps to both. It changes `rd_clk` only on whole clock cycles. It drives the flags only while `sym_valid` is high, and between frames it inserts random idle gaps of zero to two cycles. The bench also feeds frames flagged with S1 but no S0 before them, and frames flagged S0 followed by a data frame, so the sync-rejection properties are exercised as well as held.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
  localparam int SYM_W     = 8;
  localparam int Q_POS     = 6;
  localparam int CRC_W     = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam int DATA_BITS = 80;
  localparam int BLK_BITS  = DATA_BITS + CRC_W;
  localparam int CNT_W     = $clog2(BLK_BITS + 2);
endpackage

// File: rtl/qsub_sync_det.sv
module qsub_sync_det (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic s0_i,
  input  logic s1_i,
  output logic sync_evt_o,
  output logic blk_sync_o
);
  logic pend_q;

  assign sync_evt_o = acc_i && s1_i && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      blk_sync_o <= 1'b0;
    end else if (acc_i) begin
      pend_q     <= s0_i;
      blk_sync_o <= sync_evt_o;
    end
  end

  assert_sync_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_sync_o && !acc_i) |=> blk_sync_o);

  assert_orphan_s1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && s1_i && !pend_q) |=> !blk_sync_o);
endmodule

// File: rtl/qsub_crc_chk.sv
module qsub_crc_chk
  import qsub_pkg::*;
#(
  parameter int SHIFT_LEN = DATA_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 data_en_i,
  input  logic                 q_bit_i,
  input  logic                 sync_evt_i,
  output logic                 q_ok_o,
  output logic [SHIFT_LEN-1:0] q_shift_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q, crc_nxt;
  logic             feed_bit, fb;
  logic             verdict;

  assign feed_bit = (cnt_q < CNT_W'(DATA_BITS)) ? q_bit_i : ~q_bit_i;
  assign fb       = crc_q[CRC_W-1] ^ feed_bit;
  assign crc_nxt  = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  assign verdict  = (cnt_q == CNT_W'(BLK_BITS)) && (crc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= '0;
      q_ok_o <= 1'b0;
    end else if (sync_evt_i) begin
      q_ok_o <= verdict;
      cnt_q  <= '0;
      crc_q  <= '0;
    end else if (data_en_i) begin
      if (cnt_q < CNT_W'(BLK_BITS)) crc_q <= crc_nxt;
      if (cnt_q <= CNT_W'(BLK_BITS)) cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (SHIFT_LEN > 1) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_shift_o <= '0;
        else if (data_en_i) q_shift_o <= {q_shift_o[SHIFT_LEN-2:0], q_bit_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_shift_o <= '0;
        else if (data_en_i) q_shift_o <= q_bit_i;
      end
    end
  endgenerate

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLK_BITS + 1));

  assert_ok_needs_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_ok_o) |-> $past(cnt_q == CNT_W'(BLK_BITS)));
endmodule

// File: rtl/qsub_ser_out.sv
module qsub_ser_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt_i,
  input  logic dbg_en_i,
  input  logic rd_clk_i,
  input  logic q_ok_i,
  output logic q_ser_o
);
  logic rd_q, win_q, rd_fall;

  assign rd_fall = rd_q && !rd_clk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      win_q <= 1'b0;
    end else begin
      rd_q <= rd_clk_i;
      if (sync_evt_i && dbg_en_i) win_q <= 1'b1;
      else if (rd_fall)           win_q <= 1'b0;
    end
  end

  assign q_ser_o = win_q && dbg_en_i && q_ok_i;

  assert_ser_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_ser_o |-> (dbg_en_i && q_ok_i));

  assert_ser_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !sync_evt_i) |=> !q_ser_o);
endmodule

// File: rtl/qsub_sync_crc.sv
module qsub_sync_crc
  import qsub_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_valid,
  output logic                 sym_ready,
  input  logic [SYM_W-1:0]     sym_data,
  input  logic                 sym_s0,
  input  logic                 sym_s1,
  input  logic                 crc_dbg_en,
  input  logic                 rd_clk,
  output logic                 blk_sync,
  output logic                 q_ok,
  output logic                 q_ser,
  output logic [DATA_BITS-1:0] q_shift
);
  logic acc, data_en, sync_evt;

  assign sym_ready = rst_n;
  assign acc       = sym_valid && sym_ready;
  assign data_en   = acc && !sym_s0 && !sym_s1;

  qsub_sync_det u_det (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .s0_i(sym_s0), .s1_i(sym_s1),
    .sync_evt_o(sync_evt), .blk_sync_o(blk_sync)
  );

  qsub_crc_chk #(.SHIFT_LEN(DATA_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .data_en_i(data_en), .q_bit_i(sym_data[Q_POS]),
    .sync_evt_i(sync_evt), .q_ok_o(q_ok), .q_shift_o(q_shift)
  );

  qsub_ser_out u_ser (
    .clk(clk), .rst_n(rst_n), .sync_evt_i(sync_evt), .dbg_en_i(crc_dbg_en),
    .rd_clk_i(rd_clk), .q_ok_i(q_ok), .q_ser_o(q_ser)
  );

  assert_ok_only_on_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(blk_sync) |-> $stable(q_ok));
endmodule

// File: tb/qsub_sync_crc_tb_top.sv
module qsub_sync_crc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0, sym_s0 = 1'b0, sym_s1 = 1'b0;
  logic [7:0] sym_data = '0;
  logic crc_dbg_en = 1'b0, rd_clk = 1'b0;
  logic sym_ready, blk_sync, q_ok, q_ser;
  logic [79:0] q_shift;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  qsub_sync_crc dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .sym_s0(sym_s0), .sym_s1(sym_s1),
    .crc_dbg_en(crc_dbg_en), .rd_clk(rd_clk), .blk_sync(blk_sync),
    .q_ok(q_ok), .q_ser(q_ser), .q_shift(q_shift)
  );

  function automatic logic [15:0] crc_of(input logic [79:0] d);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic f = c[15] ^ d[i];
      c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic q, input logic s0, input logic s1, input bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    sym_valid = 1'b1;
    sym_data  = 8'($urandom);
    sym_data[6] = q;
    sym_s0 = s0; sym_s1 = s1;
    @(negedge clk);
    sym_valid = 1'b0; sym_s0 = 1'b0; sym_s1 = 1'b0;
  endtask

  // Send n data frames of Q vector v (MSB first, top n bits of 96), then S0, S1.
  task automatic block(input logic [95:0] v, input int n, input bit exp_ok);
    for (int i = 0; i < n; i++) frame(v[95 - i], 1'b0, 1'b0, 1'b1);
    frame(1'b0, 1'b1, 1'b0, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1);
    check("R2 blk_sync after S0,S1", 80'(blk_sync), 80'(1));
    check("R5 q_ok verdict", 80'(q_ok), 80'(exp_ok));
  endtask

  function automatic logic [95:0] good_vec(input logic [79:0] d);
    return {d, ~crc_of(d)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [95:0] v;
    logic [79:0] d;
    void'($urandom(32'd4242));
    #1;
    check("R1 ready low in reset", 80'(sym_ready), 80'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 blk_sync reset", 80'(blk_sync), 80'(0));
    check("R8 q_ok reset", 80'(q_ok), 80'(0));
    check("R8 q_ser reset", 80'(q_ser), 80'(0));
    check("R8 q_shift reset", q_shift, 80'(0));
    check("R1 ready out of reset", 80'(sym_ready), 80'(1));

    // Directed: good block from reset
    d = {16'hA5C3, 64'h0123_4567_89AB_CDEF};
    v = good_vec(d);
    block(v, 96, 1'b1);
    check("R4 q_shift last 80 Q bits", q_shift, v[79:0]);
    // R2 hold through idle then drop after next frame
    repeat (3) @(negedge clk);
    check("R2 blk_sync holds idle", 80'(blk_sync), 80'(1));
    frame(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 blk_sync drops", 80'(blk_sync), 80'(0));
    check("R4 q_shift newest bit0", 80'(q_shift[0]), 80'(1));

    // R3: S0 then data then S1 -> no sync; orphan S1 -> no sync
    frame(1'b0, 1'b1, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 broken pair no sync", 80'(blk_sync), 80'(0));
    check("R6 q_ok held without sync", 80'(q_ok), 80'(1));
    frame(1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 orphan S1 no sync", 80'(blk_sync), 80'(0));
    // That partial block closes with a wrong length -> fail
    frame(1'b0, 1'b1, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 short block fails", 80'(q_ok), 80'(0));

    // R5: 95 frames fails; 97 frames fails
    v = good_vec(80'hFFFF_0000_1234_5678_9ABC);
    block(v, 95, 1'b0);
    block(v, 96, 1'b1);
    block({v[95:0]}, 96, 1'b1);
    frame(1'b1, 1'b0, 1'b0, 1'b1);
    block(v, 96, 1'b0);

    // R7 serial readout
    crc_dbg_en = 1'b1;
    block(good_vec(80'h1), 96, 1'b1);
    check("R7 q_ser shows verdict", 80'(q_ser), 80'(1));
    rd_clk = 1'b1; @(negedge clk);
    check("R7 q_ser before fall", 80'(q_ser), 80'(1));
    rd_clk = 1'b0; @(negedge clk);
    check("R7 q_ser cleared on rd_clk fall", 80'(q_ser), 80'(0));
    block(good_vec(80'h2), 96, 1'b1);
    crc_dbg_en = 1'b0; #1;
    check("R7 q_ser off without debug", 80'(q_ser), 80'(0));
    crc_dbg_en = 1'b1; #1;
    block(good_vec(80'h3), 95, 1'b0);
    check("R7 q_ser low on bad verdict", 80'(q_ser), 80'(0));
    crc_dbg_en = 1'b0;

    // Random blocks
    for (int b = 0; b < 20; b++) begin
      bit corrupt;
      d = {16'($urandom), $urandom, $urandom};
      v = good_vec(d);
      corrupt = ($urandom_range(0, 2) == 0);
      if (corrupt) v[$urandom_range(0, 95)] ^= 1'b1;
      block(v, 96, !corrupt);
      check("R4 q_shift random", q_shift, v[79:0]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule